// File: doc/BRIEF.md
# 100BASE-FX over a Fixed-Rate Serializer: Bit-Replication Adapter

This block lets Fast-Ethernet line coding travel through a serializer that only runs at 1.25 Gbps. It runs on one 125 MHz clock, one 10-bit serializer word per cycle. In the transmit direction a nibble with its group kind is taken on each pulse of a 25 MHz nibble tick. The nibble is mapped to a 5-bit code group and NRZI-coded. Each resulting line bit fills one whole 10-bit word: ten copies of the same level.

In the receive direction every 10-bit word is treated as ten samples of one line bit. A majority vote settles the level, and a five-five split keeps the level already held. The level stream is NRZI-decoded, and the adapter searches the bit stream for the start-of-stream pair J then K to find code-group boundaries. Once aligned it hands back one decoded group every five cycles with its kind, its nibble and an error flag for invalid codes. The external 25 MHz divider supplies the transmit tick, and that tick must be phase-locked to the same reference.

Top module: `fx100_oversample_adapter`

## Requirements
- R1: At each cycle where `nib_tick` is high, `tx_kind` selects the code group: 0 idle (11111), 1 data, 2 J (11000), 3 K (10001). Data nibbles 0 to F map in order to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: Code-group bits leave most significant bit first, one line bit per clock. A line bit of 1 toggles the NRZI level and 0 keeps it. `tx_word` always shows the current level replicated in all 10 bits.
- R3: The first bit of a group sampled at one edge reaches `tx_word` after the following edge. When no new group has been loaded, the line bit is 1 (idle fill), including after reset.
- R4: The received level is 1 when six or more of the ten `rx_word` bits are 1, and 0 when four or fewer are 1.
- R5: A word with exactly five ones keeps the previously decided level.
- R6: The recovered line bit is the decided level XOR the previously decided level. The held level starts at 0 after reset.
- R7: Alignment is taken when the last ten recovered bits equal 1100010001 (J followed by K), in any phase. `rx_locked` then rises and stays high until reset, and that cycle reports kind K. No group is reported before the first lock.
- R8: After alignment, every fifth recovered bit closes a group. `rx_valid` pulses for one cycle and `rx_kind`, `rx_nibble` and `rx_err` hold their values until the next group.
- R9: Closed groups are decoded with the R1 table in reverse, to kinds 0 idle, 1 data, 2 J, 3 K. Non-data kinds report nibble 0.
- R10: A group not listed in R1 sets `rx_err` with kind 0 and nibble 0 for exactly one group period.
- R11: While `rst` (synchronous, active high) is asserted, `tx_word` is all zeros and `rx_valid`, `rx_locked`, `rx_err`, `rx_kind` and `rx_nibble` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz word clock |
| rst | input | 1 | Synchronous reset, active high |
| nib_tick | input | 1 | One-cycle 25 MHz nibble strobe for transmit |
| tx_kind | input | 2 | Transmit group kind |
| tx_nibble | input | 4 | Transmit data nibble |
| tx_word | output | 10 | Serializer word, one replicated line bit |
| rx_word | input | 10 | Deserializer word, ten samples of one line bit |
| rx_valid | output | 1 | New received group this cycle |
| rx_kind | output | 2 | Received group kind |
| rx_nibble | output | 4 | Received data nibble |
| rx_err | output | 1 | Invalid received code group |
| rx_locked | output | 1 | Code-group alignment found |

## Verification
The receive side is tried with three patterns. Clean loopback of the block's own transmit stream shows that the coding, NRZI and alignment agree with each other end to end. Loopback with up to four flipped samples per word separates a true majority vote from a single-sample pick. A bench-built line stream covers the remaining cases: five-five ties where the held level is 1, invalid groups (00000, 00100, 01101), and two stray bits before a second J/K pair. Ties on a held 1 expose a tie that is wrongly forced to 0. The invalid groups exercise the error path, and the stray bits force a realignment at a new phase.

// File: rtl/fx100_pkg.sv
package fx100_pkg;
    localparam int NIB_W = 4;
    localparam int GRP_W = 5;

    typedef enum logic [1:0] {
        KIND_IDLE = 2'd0,
        KIND_DATA = 2'd1,
        KIND_J    = 2'd2,
        KIND_K    = 2'd3
    } grp_kind_e;

    localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
    localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
    localparam logic [GRP_W-1:0] CG_K    = 5'b10001;

    typedef struct packed {
        logic             ok;
        grp_kind_e        kind;
        logic [NIB_W-1:0] nib;
    } grp_dec_t;

    function automatic logic [GRP_W-1:0] data_code(input logic [NIB_W-1:0] n);
        logic [GRP_W-1:0] c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

    function automatic logic [GRP_W-1:0] kind_code(input grp_kind_e k, input logic [NIB_W-1:0] n);
        logic [GRP_W-1:0] c;
        case (k)
            KIND_DATA: c = data_code(n);
            KIND_J:    c = CG_J;
            KIND_K:    c = CG_K;
            default:   c = CG_IDLE;
        endcase
        return c;
    endfunction

    // Reverse lookup computed by searching the forward table.
    function automatic grp_dec_t decode_group(input logic [GRP_W-1:0] c);
        grp_dec_t r;
        r = '0;
        for (int i = 0; i < (1 << NIB_W); i++) begin
            if (data_code(NIB_W'(i)) == c) begin
                r.ok   = 1'b1;
                r.kind = KIND_DATA;
                r.nib  = NIB_W'(i);
            end
        end
        if (c == CG_IDLE) begin
            r.ok = 1'b1; r.kind = KIND_IDLE;
        end else if (c == CG_J) begin
            r.ok = 1'b1; r.kind = KIND_J;
        end else if (c == CG_K) begin
            r.ok = 1'b1; r.kind = KIND_K;
        end
        return r;
    endfunction
endpackage

// File: rtl/fx100_tx_coder.sv
module fx100_tx_coder
    import fx100_pkg::*;
#(
    parameter int OSR = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  grp_kind_e        kind,
    input  logic [NIB_W-1:0] nib,
    output logic [OSR-1:0]   word
);
    typedef struct packed {
        logic [GRP_W-1:0] sh;
        logic             lvl;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // NRZI: a one toggles the line level
        st_d.lvl = st_q.lvl ^ st_q.sh[GRP_W-1];
        if (tick) begin
            st_d.sh = kind_code(kind, nib);
        end else begin
            st_d.sh = {st_q.sh[GRP_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sh  <= CG_IDLE;
            st_q.lvl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = {OSR{st_q.lvl}};
endmodule

// File: rtl/fx100_rx_slicer.sv
module fx100_rx_slicer #(
    parameter int OSR = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OSR-1:0] word,
    output logic           line_bit,
    output logic           level,
    output logic           tie
);
    localparam int CW   = $clog2(OSR + 1);
    localparam int HALF = OSR / 2;

    typedef struct packed {
        logic lvl;
    } sl_st_t;

    sl_st_t         st_d, st_q;
    logic [CW-1:0]  ones;
    logic           vote_one;

    always_comb begin
        ones = '0;
        for (int i = 0; i < OSR; i++) begin
            ones = ones + CW'(word[i]);
        end
    end

    assign vote_one = (ones > CW'(HALF));

    generate
        if (OSR % 2 == 0) begin : g_even
            assign tie = (ones == CW'(HALF));
        end else begin : g_odd
            assign tie = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.lvl = tie ? st_q.lvl : vote_one;
        line_bit = st_d.lvl ^ st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/fx100_rx_aligner.sv
module fx100_rx_aligner
    import fx100_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_bit,
    output logic             valid,
    output grp_kind_e        kind,
    output logic [NIB_W-1:0] nib,
    output logic             err,
    output logic             locked
);
    localparam int HW   = 2 * GRP_W;
    localparam int CNTW = $clog2(GRP_W);
    localparam logic [HW-1:0]   SSD_PAIR = {CG_J, CG_K};
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(GRP_W - 1);

    typedef struct packed {
        logic [HW-1:0]    hist;
        logic [CNTW-1:0]  cnt;
        logic             locked;
        logic             valid;
        grp_kind_e        kind;
        logic [NIB_W-1:0] nib;
        logic             err;
    } al_st_t;

    al_st_t   st_d, st_q;
    grp_dec_t grp;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.hist  = {st_q.hist[HW-2:0], line_bit};
        grp        = decode_group(st_d.hist[GRP_W-1:0]);
        if (st_d.hist == SSD_PAIR) begin
            // start-of-stream pair: take this phase as the group boundary
            st_d.locked = 1'b1;
            st_d.cnt    = '0;
            st_d.valid  = 1'b1;
            st_d.kind   = KIND_K;
            st_d.nib    = '0;
            st_d.err    = 1'b0;
        end else if (st_q.locked) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt   = '0;
                st_d.valid = 1'b1;
                if (grp.ok) begin
                    st_d.kind = grp.kind;
                    st_d.nib  = grp.nib;
                    st_d.err  = 1'b0;
                end else begin
                    st_d.kind = KIND_IDLE;
                    st_d.nib  = '0;
                    st_d.err  = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid  = st_q.valid;
    assign kind   = st_q.kind;
    assign nib    = st_q.nib;
    assign err    = st_q.err;
    assign locked = st_q.locked;
endmodule

// File: rtl/fx100_oversample_adapter.sv
module fx100_oversample_adapter
    import fx100_pkg::*;
#(
    parameter int OSR = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nib_tick,
    input  logic [1:0]       tx_kind,
    input  logic [NIB_W-1:0] tx_nibble,
    output logic [OSR-1:0]   tx_word,
    input  logic [OSR-1:0]   rx_word,
    output logic             rx_valid,
    output logic [1:0]       rx_kind,
    output logic [NIB_W-1:0] rx_nibble,
    output logic             rx_err,
    output logic             rx_locked
);
    logic      slice_bit;
    logic      slice_lvl;
    logic      slice_tie;
    grp_kind_e al_kind;

    fx100_tx_coder #(.OSR(OSR)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (nib_tick),
        .kind (grp_kind_e'(tx_kind)),
        .nib  (tx_nibble),
        .word (tx_word)
    );

    fx100_rx_slicer #(.OSR(OSR)) u_slice (
        .clk      (clk),
        .rst      (rst),
        .word     (rx_word),
        .line_bit (slice_bit),
        .level    (slice_lvl),
        .tie      (slice_tie)
    );

    fx100_rx_aligner u_align (
        .clk      (clk),
        .rst      (rst),
        .line_bit (slice_bit),
        .valid    (rx_valid),
        .kind     (al_kind),
        .nib      (rx_nibble),
        .err      (rx_err),
        .locked   (rx_locked)
    );

    assign rx_kind = al_kind;
endmodule

// File: rtl/fx100_adapter_checker.sv
module fx100_adapter_checker #(
    parameter int OSR = 10
) (
    input logic           clk,
    input logic           rst,
    input logic [OSR-1:0] tx_word,
    input logic [OSR-1:0] rx_word,
    input logic           rx_valid,
    input logic [1:0]     rx_kind,
    input logic [3:0]     rx_nibble,
    input logic           rx_err,
    input logic           rx_locked,
    input logic           slice_lvl,
    input logic           slice_tie
);
    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (tx_word == '0 && !rx_valid && !rx_locked && !rx_err));

    assert_tx_swing_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_word != $past(tx_word)) |-> (tx_word == ~$past(tx_word)));

    assert_vote_one_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(rx_word) > OSR / 2) |=> slice_lvl);

    assert_vote_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(rx_word) < (OSR + 1) / 2) |=> !slice_lvl);

    assert_tie_hold_R5: assert property (@(posedge clk) disable iff (rst)
        slice_tie |=> (slice_lvl == $past(slice_lvl)));

    assert_valid_needs_lock_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_locked);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        rx_locked |=> rx_locked);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> ($stable(rx_kind) && $stable(rx_nibble) && $stable(rx_err)));

    assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (rx_kind == 2'd0 && rx_nibble == 4'd0));
endmodule

bind fx100_oversample_adapter fx100_adapter_checker #(.OSR(OSR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_word   (tx_word),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .rx_kind   (rx_kind),
    .rx_nibble (rx_nibble),
    .rx_err    (rx_err),
    .rx_locked (rx_locked),
    .slice_lvl (slice_lvl),
    .slice_tie (slice_tie)
);

// File: tb/fx100_oversample_adapter_test.sv
module fx100_oversample_adapter_test;
    localparam int OSR = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           nib_tick = 1'b0;
    logic [1:0]     tx_kind = 2'd0;
    logic [3:0]     tx_nibble = 4'd0;
    logic [OSR-1:0] tx_word;
    logic [OSR-1:0] rx_word = '0;
    logic           rx_valid;
    logic [1:0]     rx_kind;
    logic [3:0]     rx_nibble;
    logic           rx_err;
    logic           rx_locked;

    always #4 clk = ~clk;

    fx100_oversample_adapter #(.OSR(OSR)) uut (
        .clk(clk), .rst(rst), .nib_tick(nib_tick), .tx_kind(tx_kind),
        .tx_nibble(tx_nibble), .tx_word(tx_word), .rx_word(rx_word),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_nibble(rx_nibble),
        .rx_err(rx_err), .rx_locked(rx_locked)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int cyc = 0;

    bit [4:0] cgtab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    int ssd [10] = '{1, 1, 0, 0, 0, 1, 0, 0, 0, 1};

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit [4:0] enc(int k, int n);
        case (k)
            1:       return cgtab[n];
            2:       return 5'b11000;
            3:       return 5'b10001;
            default: return 5'b11111;
        endcase
    endfunction

    // transmit reference: queue of pending line bits
    int txq[$];
    bit mtl = 0;
    task automatic tx_step(bit tick, int k, int n);
        int b;
        bit [4:0] c;
        b = (txq.size() > 0) ? txq.pop_front() : 1;
        mtl = mtl ^ b[0];
        if (tick) begin
            c = enc(k, n);
            txq.delete();
            for (int i = 4; i >= 0; i--) txq.push_back(int'(c[i]));
        end
    endtask

    // receive reference
    bit mrl = 0;
    int hq[$];
    bit mlk = 0;
    int mcnt = 0;
    bit ev = 0;
    int ek = 0;
    int en = 0;
    bit ee = 0;
    int n_tie = 0, n_err = 0, n_lock = 0, n_data = 0;

    task automatic rx_step(logic [OSR-1:0] w);
        int ones;
        bit nl;
        bit b;
        bit jk;
        bit [4:0] c;
        ones = $countones(w);
        if (ones * 2 > OSR) nl = 1;
        else if (ones * 2 < OSR) nl = 0;
        else begin
            nl = mrl;
            n_tie++;
        end
        b = nl ^ mrl;
        mrl = nl;
        hq.push_back(int'(b));
        if (hq.size() > 10) void'(hq.pop_front());
        ev = 0;
        jk = (hq.size() == 10);
        for (int i = 0; i < 10 && jk; i++) if (hq[i] != ssd[i]) jk = 0;
        if (jk) begin
            if (!mlk || mcnt != 4) n_lock++;
            mlk = 1; mcnt = 0; ev = 1; ek = 3; en = 0; ee = 0;
        end else if (mlk) begin
            mcnt++;
            if (mcnt == 5) begin
                mcnt = 0;
                ev = 1; ee = 0; en = 0;
                for (int i = 0; i < 5; i++) c[4-i] = hq[5+i][0];
                if (c == 5'b11111) ek = 0;
                else if (c == 5'b11000) ek = 2;
                else if (c == 5'b10001) ek = 3;
                else begin
                    ek = -1;
                    for (int i = 0; i < 16; i++) if (cgtab[i] == c) begin ek = 1; en = i; end
                    if (ek < 0) begin
                        ek = 0; ee = 1; n_err++;
                    end else n_data++;
                end
            end
        end
    endtask

    // stimulus sources
    int stim[$];       // transmit items: kind*16 + nibble
    int gq[$];         // direct receive line bits
    bit glvl = 0;

    task automatic push_item(int k, int n);
        stim.push_back(k * 16 + n);
    endtask

    task automatic push_cg(bit [4:0] c);
        for (int i = 4; i >= 0; i--) gq.push_back(int'(c[i]));
    endtask

    function automatic logic [OSR-1:0] noise(int k);
        logic [OSR-1:0] m;
        m = '0;
        while ($countones(m) < k) m[$urandom_range(OSR-1, 0)] = 1'b1;
        return m;
    endfunction

    task automatic compare();
        check(tx_word === {OSR{mtl}}, "R1/R2/R3", "tx_word", int'(tx_word), int'({OSR{mtl}}));
        check(rx_locked === mlk, "R7", "rx_locked", int'(rx_locked), int'(mlk));
        check(rx_valid === ev, "R8", "rx_valid", int'(rx_valid), int'(ev));
        check(rx_kind === 2'(ek), "R9/R4/R5/R6", "rx_kind", int'(rx_kind), ek);
        check(rx_nibble === 4'(en), "R9", "rx_nibble", int'(rx_nibble), en);
        check(rx_err === ee, "R10", "rx_err", int'(rx_err), int'(ee));
    endtask

    // mode 0: loopback of tx_word with noise; mode 1: direct line bits
    task automatic drive_step(int mode, int maxflip, int tiepct);
        logic [OSR-1:0] w;
        int item;
        int b;
        bit tick;
        tick = (cyc % 5 == 0);
        item = 0;
        if (tick && stim.size() > 0) item = stim.pop_front();
        nib_tick  = tick;
        tx_kind   = 2'(item / 16);
        tx_nibble = 4'(item % 16);
        if (mode == 0) begin
            w = tx_word ^ noise($urandom_range(maxflip, 0));
        end else begin
            b = (gq.size() > 0) ? gq.pop_front() : 1;
            if (b == 0 && $urandom_range(99, 0) < tiepct) begin
                w = 10'b0000011111;
            end else begin
                glvl = glvl ^ b[0];
                w = {OSR{glvl}} ^ noise($urandom_range(maxflip, 0));
            end
        end
        rx_word = w;
        tx_step(tick, item / 16, item % 16);
        rx_step(w);
        cyc++;
    endtask

    task automatic run(int n, int mode, int maxflip, int tiepct);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            drive_step(mode, maxflip, tiepct);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        // R11: reset values
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tx_word === '0, "R11", "tx_word in reset", int'(tx_word), 0);
            check(rx_valid === 1'b0, "R11", "rx_valid in reset", int'(rx_valid), 0);
            check(rx_locked === 1'b0, "R11", "rx_locked in reset", int'(rx_locked), 0);
            check(rx_err === 1'b0, "R11", "rx_err in reset", int'(rx_err), 0);
            check(rx_kind === 2'd0 && rx_nibble === 4'd0, "R11", "rx kind/nibble in reset",
                  int'({rx_kind, rx_nibble}), 0);
        end
        rst = 1'b0;
        drive_step(0, 0, 0);

        // stage 1: clean loopback, idle fill then every data code (R1, R3, R7, R9)
        run(23, 0, 0, 0);
        for (int i = 0; i < 6; i++) push_item(0, 0);
        push_item(2, 0); push_item(3, 0);
        for (int i = 0; i < 16; i++) push_item(1, i);
        for (int i = 0; i < 4; i++) push_item(0, 0);
        run(stim.size() * 5 + 30, 0, 0, 0);

        // stage 2: loopback with up to four flipped samples (R4)
        for (int f = 0; f < 3; f++) begin
            push_item(2, 0); push_item(3, 0);
            for (int i = 0; i < 20; i++) push_item(1, $urandom_range(15, 0));
            for (int i = 0; i < 4; i++) push_item(0, 0);
        end
        run(stim.size() * 5 + 30, 0, 4, 0);

        // stage 3: direct line stream with ties, invalid groups, realignment
        glvl = mtl;
        for (int i = 0; i < 4; i++) push_cg(5'b11111);
        push_cg(5'b11000); push_cg(5'b10001);
        push_cg(cgtab[5]); push_cg(cgtab[10]);
        push_cg(5'b00000); push_cg(5'b00100); push_cg(5'b01101);
        push_cg(cgtab[3]); push_cg(5'b11111); push_cg(5'b11111);
        gq.push_back(1); gq.push_back(1);
        push_cg(5'b11000); push_cg(5'b10001);
        push_cg(cgtab[9]); push_cg(cgtab[0]); push_cg(cgtab[15]);
        for (int i = 0; i < 3; i++) push_cg(5'b11111);
        run(gq.size() + 40, 1, 4, 35);

        // coverage of the corner cases the requirements name
        check(n_tie > 0, "R5", "tie words seen", n_tie, 1);
        check(n_err >= 3, "R10", "invalid groups decoded", n_err, 3);
        check(n_lock >= 2, "R7", "alignments taken", n_lock, 2);
        check(n_data >= 16, "R9", "data groups decoded", n_data, 16);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end
endmodule